// File: doc/BRIEF.md
# Overlap-Safe Rectangle Copy Engine

This block moves a rectangle of pixels from one place in a framebuffer to another place in the same framebuffer. Software programs a source corner, a destination corner, a pitch/base word and a pair of direction bits through a small register-write port. Writing the size word launches the copy. The engine then walks the rectangle one pixel at a time. For each pixel it issues a read of the source pixel to a synchronous pixel-addressed memory and, one cycle later, writes the returned value to the destination pixel.

The direction bits pick the walk order on each axis independently. When a bit is set, that axis runs in increasing order from the given corner. When it is cleared, that axis starts at the far edge of the rectangle and runs backwards. When software sets each bit exactly when the source coordinate on that axis is at or beyond the destination coordinate, an overlapping copy reads every pixel before it is overwritten. `busy` covers the whole operation, and command writes that arrive while it is high have no effect.

Top module: `rect_copy_engine`

## Requirements
- R1: Command writes select a register with `cmd_sel`: 0 = source corner, 1 = destination corner, 2 = direction bits, 3 = pitch/base, 4 = size (trigger). Corner words carry Y in bits 31:16 and X in bits 15:0. The size word carries height in bits 31:16 and width in bits 15:0.
- R2: The pixel address of (y, x) is base*1024 + y*pitch + x. The base is bits 21:0 of the pitch/base word and the pitch is bits 31:22.
- R3: Direction bit 0 set: columns run from x upward. Cleared: columns run from x+width-1 downward. The same column order applies to source and destination.
- R4: Direction bit 1 set: rows run from y downward in the picture (increasing y). Cleared: rows run from y+height-1 toward y. The same row order applies to source and destination.
- R5: The walk is row by row, with all columns of a row before the next row. Every pixel is read in one cycle and written in the next, with the value read. With direction bits chosen as (source ≥ destination) per axis, the destination ends up holding the original source rectangle even when the two overlap, and no other location changes.
- R6: A size write with nonzero width and height raises `busy` in the next cycle. `busy` stays high for exactly 2*width*height cycles and falls right after the last write. Exactly width*height writes are made.
- R7: A size write with zero width or zero height makes no memory access and leaves `busy` low.
- R8: Command writes of any register while `busy` is high are ignored. They neither restart nor resize the running copy, and later copies use the values held before them.
- R9: Reset clears `busy` and sets both direction bits to increasing order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Command register write strobe |
| cmd_sel | input | 3 | Register select (see R1) |
| cmd_data | input | 32 | Command write data |
| busy | output | 1 | Copy in progress |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | ADDR_W | Source pixel address |
| mem_rd_data | input | PIX_W | Read data, valid the cycle after the request |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wr_addr | output | ADDR_W | Destination pixel address |
| mem_wr_data | output | PIX_W | Write data |

## Verification
The main sweep runs source/destination offsets from -2 to +2 on both axes against four rectangle shapes, alternating between two pitch/base settings. Each run checks the destination addresses in write order, which separates the forward and backward walk on each axis, and checks the whole memory image against a copy made from a snapshot. That comparison exposes any overlap that was read after being overwritten, any stray write, and any wrong pitch or base term. Separate runs cover the direction bits at their reset value with no write to them, zero-width and zero-height sizes, and register writes made mid-copy whose effect is checked both on the current copy's write count and on the next copy's source and order.

// File: rtl/rc_pkg.sv
package rc_pkg;
  localparam int WORD_W     = 32;
  localparam int CRD_W      = 16;
  localparam int PITCH_LSB  = 22;
  localparam int PITCH_W    = WORD_W - PITCH_LSB;
  localparam int BASE_SHIFT = 10;

  typedef enum logic [2:0] {
    SEL_SRC   = 3'd0,
    SEL_DST   = 3'd1,
    SEL_DIR   = 3'd2,
    SEL_PITCH = 3'd3,
    SEL_SIZE  = 3'd4
  } rc_sel_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_READ  = 2'd1,
    PH_WRITE = 2'd2
  } rc_phase_e;

  // Position along one axis for walk index idx.
  function automatic logic [CRD_W-1:0] walk_pos(
    input logic [CRD_W-1:0] start,
    input logic [CRD_W-1:0] len,
    input logic [CRD_W-1:0] idx,
    input logic             inc
  );
    return inc ? (start + idx) : (start + len - 1'b1 - idx);
  endfunction

  // Linear pixel address from the pitch/base word.
  function automatic logic [WORD_W-1:0] lin_addr(
    input logic [WORD_W-1:0] pw,
    input logic [CRD_W-1:0]  y,
    input logic [CRD_W-1:0]  x
  );
    logic [WORD_W-1:0] base_b;
    logic [WORD_W-1:0] row_off;
    base_b  = {pw[PITCH_LSB-1:0], {BASE_SHIFT{1'b0}}};
    row_off = {{(WORD_W-CRD_W){1'b0}}, y} * {{PITCH_LSB{1'b0}}, pw[WORD_W-1:PITCH_LSB]};
    return base_b + row_off + {{(WORD_W-CRD_W){1'b0}}, x};
  endfunction
endpackage

// File: rtl/rc_cmd_regs.sv
module rc_cmd_regs
  import rc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic [2:0]        cmd_sel,
  input  logic [WORD_W-1:0] cmd_data,
  input  logic              busy,
  output logic [WORD_W-1:0] src_yx,
  output logic [WORD_W-1:0] dst_yx,
  output logic [WORD_W-1:0] size_wh,
  output logic [WORD_W-1:0] pitch_word,
  output logic [1:0]        dir_bits,
  output logic              start_evt,
  output logic              zero_evt
);
  logic accept;
  logic size_wr;
  logic size_empty;

  assign accept     = cmd_we && !busy;
  assign size_wr    = accept && (rc_sel_e'(cmd_sel) == SEL_SIZE);
  assign size_empty = (cmd_data[WORD_W-1:CRD_W] == '0) || (cmd_data[CRD_W-1:0] == '0);
  assign start_evt  = size_wr && !size_empty;
  assign zero_evt   = size_wr && size_empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_yx     <= '0;
      dst_yx     <= '0;
      size_wh    <= '0;
      pitch_word <= '0;
      dir_bits   <= 2'b11;
    end else if (accept) begin
      case (rc_sel_e'(cmd_sel))
        SEL_SRC:   src_yx     <= cmd_data;
        SEL_DST:   dst_yx     <= cmd_data;
        SEL_DIR:   dir_bits   <= cmd_data[1:0];
        SEL_PITCH: pitch_word <= cmd_data;
        SEL_SIZE:  size_wh    <= cmd_data;
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/rc_walker.sv
module rc_walker
  import rc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] size_wh,
  output logic              busy,
  output logic              rd_phase,
  output logic              wr_phase,
  output logic              last,
  output logic [CRD_W-1:0]  col,
  output logic [CRD_W-1:0]  row
);
  rc_phase_e phase;
  logic [CRD_W-1:0] w_last;
  logic [CRD_W-1:0] h_last;
  logic             row_end;

  assign w_last  = size_wh[CRD_W-1:0] - 1'b1;
  assign h_last  = size_wh[WORD_W-1:CRD_W] - 1'b1;
  assign row_end = (col == w_last);
  assign last    = row_end && (row == h_last);

  assign busy     = (phase != PH_IDLE);
  assign rd_phase = (phase == PH_READ);
  assign wr_phase = (phase == PH_WRITE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      col   <= '0;
      row   <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (start) begin
            phase <= PH_READ;
            col   <= '0;
            row   <= '0;
          end
        end
        PH_READ: phase <= PH_WRITE;
        PH_WRITE: begin
          if (last) begin
            phase <= PH_IDLE;
          end else begin
            phase <= PH_READ;
            if (row_end) begin
              col <= '0;
              row <= row + 1'b1;
            end else begin
              col <= col + 1'b1;
            end
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rc_addr_gen.sv
module rc_addr_gen
  import rc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [WORD_W-1:0] src_yx,
  input  logic [WORD_W-1:0] dst_yx,
  input  logic [WORD_W-1:0] size_wh,
  input  logic [WORD_W-1:0] pitch_word,
  input  logic [1:0]        dir_bits,
  input  logic [CRD_W-1:0]  col,
  input  logic [CRD_W-1:0]  row,
  output logic [ADDR_W-1:0] src_addr,
  output logic [ADDR_W-1:0] dst_addr
);
  localparam int N_END = 2;

  logic [N_END-1:0][WORD_W-1:0] corner;
  logic [N_END-1:0][ADDR_W-1:0] addr;

  assign corner[0] = src_yx;
  assign corner[1] = dst_yx;

  for (genvar e = 0; e < N_END; e++) begin : g_end
    logic [CRD_W-1:0]  px;
    logic [CRD_W-1:0]  py;
    logic [WORD_W-1:0] full;
    assign px      = walk_pos(corner[e][CRD_W-1:0], size_wh[CRD_W-1:0], col, dir_bits[0]);
    assign py      = walk_pos(corner[e][WORD_W-1:CRD_W], size_wh[WORD_W-1:CRD_W], row, dir_bits[1]);
    assign full    = lin_addr(pitch_word, py, px);
    assign addr[e] = full[ADDR_W-1:0];
  end

  assign src_addr = addr[0];
  assign dst_addr = addr[1];
endmodule

// File: rtl/rect_copy_engine.sv
module rect_copy_engine
  import rc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PIX_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic [2:0]        cmd_sel,
  input  logic [31:0]       cmd_data,
  output logic              busy,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [PIX_W-1:0]  mem_rd_data,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [PIX_W-1:0]  mem_wr_data
);
  logic [WORD_W-1:0] src_yx;
  logic [WORD_W-1:0] dst_yx;
  logic [WORD_W-1:0] size_wh;
  logic [WORD_W-1:0] pitch_word;
  logic [1:0]        dir_bits;
  logic              start_evt;
  logic              zero_evt;
  logic              rd_phase;
  logic              wr_phase;
  logic              last;
  logic [CRD_W-1:0]  col;
  logic [CRD_W-1:0]  row;
  logic [ADDR_W-1:0] src_addr;
  logic [ADDR_W-1:0] dst_addr;

  // Named events for the checker
  logic last_evt;
  logic cmd_drop;

  rc_cmd_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_we     (cmd_we),
    .cmd_sel    (cmd_sel),
    .cmd_data   (cmd_data),
    .busy       (busy),
    .src_yx     (src_yx),
    .dst_yx     (dst_yx),
    .size_wh    (size_wh),
    .pitch_word (pitch_word),
    .dir_bits   (dir_bits),
    .start_evt  (start_evt),
    .zero_evt   (zero_evt)
  );

  rc_walker u_walk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start_evt),
    .size_wh  (size_wh),
    .busy     (busy),
    .rd_phase (rd_phase),
    .wr_phase (wr_phase),
    .last     (last),
    .col      (col),
    .row      (row)
  );

  rc_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .src_yx     (src_yx),
    .dst_yx     (dst_yx),
    .size_wh    (size_wh),
    .pitch_word (pitch_word),
    .dir_bits   (dir_bits),
    .col        (col),
    .row        (row),
    .src_addr   (src_addr),
    .dst_addr   (dst_addr)
  );

  assign last_evt = wr_phase && last;
  assign cmd_drop = cmd_we && busy;

  assign mem_rd_en   = rd_phase;
  assign mem_rd_addr = src_addr;
  assign mem_wr_en   = wr_phase;
  assign mem_wr_addr = dst_addr;
  assign mem_wr_data = mem_rd_data;
endmodule

// File: rtl/rc_checker.sv
module rc_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        start_evt,
  input logic        zero_evt,
  input logic        last_evt,
  input logic        cmd_drop,
  input logic        busy,
  input logic        mem_rd_en,
  input logic        mem_wr_en,
  input logic [31:0] src_yx,
  input logic [31:0] dst_yx,
  input logic [31:0] size_wh,
  input logic [31:0] pitch_word,
  input logic [1:0]  dir_bits
);
  // R6: a launch raises busy on the next cycle
  a_r6_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> busy);

  // R6: the last write ends the operation
  a_r6_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    last_evt |=> !busy);

  // R5: each read is followed by its write
  a_r5_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> mem_wr_en);

  // R5: every write was preceded by a read
  a_r5_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> $past(mem_rd_en));

  // R7: an empty size starts nothing
  a_r7_zero_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt |=> !busy && !mem_rd_en);

  // R8: writes while busy leave the registers unchanged
  a_r8_drop_holds_regs: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_drop |=> $stable(src_yx) && $stable(dst_yx) && $stable(size_wh)
                 && $stable(pitch_word) && $stable(dir_bits));

  // R8: a size write while busy does not relaunch
  a_r8_no_relaunch: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start_evt);
endmodule

bind rect_copy_engine rc_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_evt  (start_evt),
  .zero_evt   (zero_evt),
  .last_evt   (last_evt),
  .cmd_drop   (cmd_drop),
  .busy       (busy),
  .mem_rd_en  (mem_rd_en),
  .mem_wr_en  (mem_wr_en),
  .src_yx     (src_yx),
  .dst_yx     (dst_yx),
  .size_wh    (size_wh),
  .pitch_word (pitch_word),
  .dir_bits   (dir_bits)
);

// File: tb/rect_copy_engine_test.sv
module rect_copy_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_N      = 2048;
  localparam int LOG_N      = 64;
  localparam int ADDR_W     = 32;
  localparam int PIX_W      = 8;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic              rst_n;
  logic              cmd_we;
  logic [2:0]        cmd_sel;
  logic [31:0]       cmd_data;
  logic              busy;
  logic              mem_rd_en;
  logic [ADDR_W-1:0] mem_rd_addr;
  logic [PIX_W-1:0]  mem_rd_data;
  logic              mem_wr_en;
  logic [ADDR_W-1:0] mem_wr_addr;
  logic [PIX_W-1:0]  mem_wr_data;

  rect_copy_engine #(.ADDR_W(ADDR_W), .PIX_W(PIX_W)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_sel(cmd_sel),
    .cmd_data(cmd_data), .busy(busy), .mem_rd_en(mem_rd_en),
    .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data)
  );

  logic [7:0] ram  [MEM_N];
  logic [7:0] orig [MEM_N];
  logic [7:0] expm [MEM_N];
  int wlog [LOG_N];
  int wcnt;
  int nchk;
  int nfail;
  bit done;

  // Synchronous pixel memory, one cycle read latency
  always @(posedge clk) begin
    if (mem_rd_en) mem_rd_data <= ram[mem_rd_addr[10:0]];
    if (mem_wr_en) begin
      ram[mem_wr_addr[10:0]] <= mem_wr_data;
      if (wcnt < LOG_N) wlog[wcnt] = int'(mem_wr_addr);
      wcnt = wcnt + 1;
    end
  end

  function automatic int baddr(input logic [31:0] pw, input int y, input int x);
    return int'(pw[21:0]) * 1024 + int'(pw[31:22]) * y + x;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr_cmd(input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    cmd_we   = 1'b1;
    cmd_sel  = sel;
    cmd_data = data;
    @(negedge clk);
    cmd_we   = 1'b0;
  endtask

  task automatic fill(input int seed);
    for (int i = 0; i < MEM_N; i++) begin
      ram[i]  = 8'(i * 13 + seed * 5 + 1);
      orig[i] = 8'(i * 13 + seed * 5 + 1);
    end
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 10000) begin
      @(negedge clk);
      n++;
    end
  endtask

  // Checks order of writes and final image for one completed copy
  task automatic check_result(input int sx, input int sy, input int dx, input int dy,
                              input int w, input int h, input logic [31:0] pw,
                              input bit xinc, input bit yinc, input string tag);
    int bad;
    int ex;
    bad = 0;
    for (int k = 0; k < w * h && k < LOG_N; k++) begin
      int r;
      int c;
      r  = k / w;
      c  = k % w;
      ex = baddr(pw, yinc ? dy + r : dy + h - 1 - r, xinc ? dx + c : dx + w - 1 - c);
      if (wlog[k] != ex) bad++;
    end
    chk(bad == 0, {tag, " R3 R4 R2 write order"}, bad, 0);
    for (int i = 0; i < MEM_N; i++) expm[i] = orig[i];
    for (int r = 0; r < h; r++)
      for (int c = 0; c < w; c++)
        expm[baddr(pw, dy + r, dx + c)] = orig[baddr(pw, sy + r, sx + c)];
    bad = 0;
    for (int i = 0; i < MEM_N; i++) if (ram[i] !== expm[i]) bad++;
    chk(bad == 0, {tag, " R5 R2 image"}, bad, 0);
  endtask

  task automatic run_copy(input int sx, input int sy, input int dx, input int dy,
                          input int w, input int h, input logic [31:0] pw,
                          input bit set_dir, input bit xinc, input bit yinc,
                          input int seed, input string tag);
    int n;
    fill(seed);
    wr_cmd(3'd3, pw);
    wr_cmd(3'd0, {16'(sy), 16'(sx)});
    wr_cmd(3'd1, {16'(dy), 16'(dx)});
    if (set_dir) wr_cmd(3'd2, {30'd0, yinc, xinc});
    wcnt = 0;
    wr_cmd(3'd4, {16'(h), 16'(w)});
    if (w == 0 || h == 0) begin
      chk(busy == 1'b0, {tag, " R7 busy stays low"}, busy, 0);
      repeat (4) @(negedge clk);
      chk(wcnt == 0, {tag, " R7 no writes"}, wcnt, 0);
    end else begin
      chk(busy == 1'b1, {tag, " R6 busy rises"}, busy, 1);
      wait_idle(n);
      chk(n == 2 * w * h, {tag, " R6 busy length"}, n, 2 * w * h);
      chk(wcnt == w * h, {tag, " R6 write count"}, wcnt, w * h);
      check_result(sx, sy, dx, dy, w, h, pw, xinc, yinc, tag);
    end
  endtask

  localparam logic [31:0] PW_A = {10'd16, 22'd1};
  localparam logic [31:0] PW_B = {10'd20, 22'd0};

  initial begin
    int op;
    int n;
    nchk = 0; nfail = 0; done = 0; wcnt = 0;
    rst_n = 1'b0; cmd_we = 1'b0; cmd_sel = '0; cmd_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R9 busy after reset", busy, 0);
    chk(mem_wr_en == 1'b0, "R9 no write after reset", mem_wr_en, 0);

    // R9: direction bits left at reset value walk forward
    run_copy(2, 3, 9, 5, 3, 2, PW_A, 1'b0, 1'b1, 1'b1, 1, "R9 default dir");

    // R1 R3 R4 R5: sweep of overlapping offsets and shapes
    op = 0;
    for (int ddy = -2; ddy <= 2; ddy++) begin
      for (int ddx = -2; ddx <= 2; ddx++) begin
        for (int s = 0; s < 4; s++) begin
          int w;
          int h;
          w = (s == 0) ? 1 : (s == 1) ? 3 : (s == 2) ? 2 : 4;
          h = (s == 0) ? 1 : (s == 1) ? 2 : (s == 2) ? 3 : 4;
          run_copy(6, 6, 6 + ddx, 6 + ddy, w, h, (op % 2 == 0) ? PW_A : PW_B,
                   1'b1, (ddx <= 0), (ddy <= 0), op + 2, "R1 sweep");
          op++;
        end
      end
    end

    // R7: empty sizes
    run_copy(1, 1, 4, 4, 0, 3, PW_A, 1'b1, 1'b1, 1'b1, 7, "R7 zero width");
    run_copy(1, 1, 4, 4, 3, 0, PW_A, 1'b1, 1'b1, 1'b1, 8, "R7 zero height");

    // R8: command writes during a copy are dropped
    fill(40);
    wr_cmd(3'd3, PW_A);
    wr_cmd(3'd0, {16'd2, 16'd2});
    wr_cmd(3'd1, {16'd8, 16'd8});
    wr_cmd(3'd2, 32'd3);
    wcnt = 0;
    wr_cmd(3'd4, {16'd2, 16'd3});
    wr_cmd(3'd0, {16'd9, 16'd9});
    wr_cmd(3'd2, 32'd0);
    wr_cmd(3'd4, {16'd5, 16'd5});
    wait_idle(n);
    chk(wcnt == 6, "R8 size write mid-copy ignored", wcnt, 6);
    fill(41);
    wcnt = 0;
    wr_cmd(3'd4, {16'd1, 16'd2});
    wait_idle(n);
    chk(wcnt == 2, "R8 follow-up write count", wcnt, 2);
    check_result(2, 2, 8, 8, 2, 1, PW_A, 1'b1, 1'b1, "R8 old regs kept");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
      $finish;
    end
  end
endmodule